// File: doc/BRIEF.md
# Dual-Channel Event Buffer DMA Controller

This block holds two independent word buffers, one for each class of event record (channel 1 and channel 2), and moves words between them and an external DMA engine. Each channel has its own request, acknowledge and end-of-transfer lines. Both channels share one data-in bus, one data-out bus and one transfer strobe that qualifies every word. Everything runs on the single system clock.

Software drives one command byte. Two bits per channel start a read burst or a write burst. A third bit per channel ends writing and prepares the channel for read-back: the number of words written becomes the read limit, and the address returns to zero. A write burst fills the buffer until the last location, unless software ends it early with the reposition bit. A read burst returns stored words from address zero up to the read limit.

The buffer depth is 2^ADDR_W words of DATA_W bits. The 32K x 32 configuration is ADDR_W=15. The default is smaller so that the block elaborates quickly.

Top module: `dma_dual_buf`

## Requirements
- R1: After reset, both requests and both end-of-transfer outputs are low, rd_data is zero, and each read limit equals the full depth.
- R2: A command with bit 3 (channel 1) or bit 5 (channel 2) set starts a write burst on that channel and resets its word address to zero. Its request is high from the next cycle. It stays high until the burst ends or the reposition bit for that channel is given.
- R3: A word moves on a channel only in a cycle where the channel is active, its acknowledge is high and xfer_stb is high. Each moved word advances the channel's address by one. A cycle with only one of acknowledge or strobe high moves nothing.
- R4: A write burst ends after the word at the last buffer address. In the following cycle the end-of-transfer output of that channel is high for exactly one cycle and its request is low.
- R5: A command with bit 6 (channel 1) or bit 7 (channel 2) set latches the count of words written by that channel's latest write burst as its read limit and rewinds its address to zero. Given during a write burst, it ends that burst with no end-of-transfer pulse. Given during a read burst, it is ignored.
- R6: A command with bit 2 (channel 1) or bit 4 (channel 2) set starts a read burst from address zero. Each moved word appears on rd_data in the cycle after its transfer edge, in address order. After the word at (read limit - 1), end-of-transfer pulses for one cycle and the request drops.
- R7: A start command on a channel whose request is already high is ignored. The burst in progress keeps its address and its end point.
- R8: For the same channel, a command byte that sets both start bits, or that sets a start bit together with the reposition bit, starts nothing on that channel.
- R9: If both channels could move a word in the same cycle, only channel 1 moves. Channel 2 keeps its address and its request.
- R10: A read start on a channel whose read limit is zero is ignored.
- R11: The two buffers are independent. Writing one channel never changes the words read back from the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command byte strobe, one cycle |
| cmd_data | input | 8 | Command byte (bits 2..7 used as listed in R2, R5, R6) |
| xfer_stb | input | 1 | Shared data-transfer strobe |
| dma_ack | input | 2 | DMA acknowledge, bit 0 = channel 1, bit 1 = channel 2 |
| wr_data | input | DATA_W | Word written into the active write channel |
| dma_req | output | 2 | DMA request per channel |
| dma_eot | output | 2 | One-cycle end-of-transfer pulse per channel |
| rd_data | output | DATA_W | Last word read from either buffer |

## Verification
The bench uses an 8-word configuration. It runs write bursts of every length from one word to full depth on one channel, each ended by the reposition command and then read back. This separates the latched-count read limit from the fixed full-buffer write end. Write bursts are interleaved with cycles where only the acknowledge or only the strobe is high, which shows whether gating uses both signals. Concurrent activity covers three cases: both channels acknowledged in the same cycles, which separates the channel 1 priority from a shared-address fault; restarts during a busy burst; and conflicting or zero-limit commands, which must leave the request low.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_RD   = 2'd1,
    CH_WR   = 2'd2
  } ch_mode_e;

  // Word count at which the running burst is complete.
  function automatic int unsigned end_count(logic writing, int unsigned rd_limit,
                                            int unsigned depth);
    return writing ? depth : rd_limit;
  endfunction

  // True when the word just moved was the final one.
  function automatic logic hits_end(int unsigned next_cnt, int unsigned fin_cnt);
    return next_cnt == fin_cnt;
  endfunction

  // Command byte bit positions for a channel (0 = channel 1).
  function automatic int unsigned rd_bit(int unsigned ch);
    return 2 + 2 * ch;
  endfunction

  function automatic int unsigned wr_bit(int unsigned ch);
    return 3 + 2 * ch;
  endfunction

  function automatic int unsigned rew_bit(int unsigned ch);
    return 6 + ch;
  endfunction

endpackage

// File: rtl/dmab_cmd_dec.sv
module dmab_cmd_dec
  import dmab_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           cmd_wr,
  input  logic [7:0]     cmd_data,
  output logic [NCH-1:0] start_rd,
  output logic [NCH-1:0] start_wr,
  output logic [NCH-1:0] rewind
);

  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic rd_b, wr_b, rw_b;
    assign rd_b = cmd_data[rd_bit(c)];
    assign wr_b = cmd_data[wr_bit(c)];
    assign rw_b = cmd_data[rew_bit(c)];
    // conflicting starts, or a start beside a rewind, start nothing
    assign start_rd[c] = cmd_wr & rd_b & ~wr_b & ~rw_b;
    assign start_wr[c] = cmd_wr & wr_b & ~rd_b & ~rw_b;
    assign rewind[c]   = cmd_wr & rw_b;
  end

endmodule

// File: rtl/dmab_ram.sv
module dmab_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (re) q <= mem[addr];
  end

endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
  import dmab_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int CNT_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_rd,
  input  logic              start_wr,
  input  logic              rewind,
  input  logic              dack,
  input  logic              stb,
  input  logic              allow,
  output logic              dreq,
  output logic              eot,
  output logic [ADDR_W-1:0] addr,
  output logic              mv,
  output logic              wr_mv,
  output logic              rd_mv
);

  ch_mode_e         mode;
  logic [CNT_W-1:0] ptr;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] limit;
  logic             active;
  logic             last;
  int unsigned      fin;

  assign active = (mode != CH_IDLE);
  assign mv     = active & dack & stb & allow;
  assign wr_mv  = mv & (mode == CH_WR);
  assign rd_mv  = mv & (mode == CH_RD);
  assign fin    = end_count(mode == CH_WR, 32'(limit), DEPTH);
  assign last   = mv & hits_end(32'(ptr) + 32'd1, fin);
  assign dreq   = active;
  assign addr   = ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode  <= CH_IDLE;
      ptr   <= '0;
      wcnt  <= '0;
      limit <= CNT_W'(DEPTH);
      eot   <= 1'b0;
    end else begin
      eot <= last;
      if (rewind && mode != CH_RD) begin
        limit <= wcnt;
        ptr   <= '0;
        mode  <= CH_IDLE;
      end else if (start_rd && !active && limit != '0) begin
        mode <= CH_RD;
        ptr  <= '0;
      end else if (start_wr && !active) begin
        mode <= CH_WR;
        ptr  <= '0;
        wcnt <= '0;
      end else if (mv) begin
        ptr <= ptr + 1'b1;
        if (mode == CH_WR) wcnt <= ptr + 1'b1;
        if (last) mode <= CH_IDLE;
      end
    end
  end

endmodule

// File: rtl/dma_dual_buf.sv
module dma_dual_buf #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_data,
  input  logic              xfer_stb,
  input  logic [1:0]        dma_ack,
  input  logic [DATA_W-1:0] wr_data,
  output logic [1:0]        dma_req,
  output logic [1:0]        dma_eot,
  output logic [DATA_W-1:0] rd_data
);

  localparam int NCH = 2;

  logic [NCH-1:0]    start_rd, start_wr, rewind;
  logic [NCH-1:0]    ch_move, ch_wmove, ch_rmove, ch_allow;
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [DATA_W-1:0] ch_q    [NCH];
  logic              rd_sel;

  dmab_cmd_dec #(.NCH(NCH)) u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_data (cmd_data),
    .start_rd (start_rd),
    .start_wr (start_wr),
    .rewind   (rewind)
  );

  // channel 1 wins a shared cycle
  assign ch_allow[0] = 1'b1;
  assign ch_allow[1] = ~ch_move[0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmab_chan #(.ADDR_W(ADDR_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_rd (start_rd[c]),
      .start_wr (start_wr[c]),
      .rewind   (rewind[c]),
      .dack     (dma_ack[c]),
      .stb      (xfer_stb),
      .allow    (ch_allow[c]),
      .dreq     (dma_req[c]),
      .eot      (dma_eot[c]),
      .addr     (ch_addr[c]),
      .mv       (ch_move[c]),
      .wr_mv    (ch_wmove[c]),
      .rd_mv    (ch_rmove[c])
    );

    dmab_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (ch_wmove[c]),
      .re    (ch_rmove[c]),
      .addr  (ch_addr[c]),
      .wd    (wr_data),
      .q     (ch_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           rd_sel <= 1'b0;
    else if (ch_rmove[0]) rd_sel <= 1'b0;
    else if (ch_rmove[1]) rd_sel <= 1'b1;
  end

  assign rd_data = rd_sel ? ch_q[1] : ch_q[0];

endmodule

// File: rtl/dmab_chk.sv
module dmab_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] cmd_data,
  input logic       xfer_stb,
  input logic [1:0] dack,
  input logic [1:0] dreq,
  input logic [1:0] eot,
  input logic [1:0] mv
);

  AST_ONE_MOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !(mv[0] && mv[1])); // R9

  for (genvar i = 0; i < 2; i++) begin : g_chk
    AST_EOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eot[i] |=> !eot[i]); // R4
    AST_EOT_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      eot[i] |-> !dreq[i]); // R4
    AST_IDLE_NO_EOT: assert property (@(posedge clk) disable iff (!rst_n)
      !dreq[i] |=> !eot[i]); // R6
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dreq[i] && !mv[i] && !(cmd_wr && cmd_data[6+i])) |=> dreq[i]); // R2
    AST_MOVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      mv[i] |-> (dreq[i] && dack[i] && xfer_stb)); // R3
    AST_REQ_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dreq[i]) |-> $past(cmd_wr)); // R7
  end

endmodule

bind dma_dual_buf dmab_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_wr   (cmd_wr),
  .cmd_data (cmd_data),
  .xfer_stb (xfer_stb),
  .dack     (dma_ack),
  .dreq     (dma_req),
  .eot      (dma_eot),
  .mv       (ch_move)
);

// File: tb/test_dma_dual_buf.sv
module test_dma_dual_buf;

  localparam int CLK_PER = 10;
  localparam int AW      = 3;
  localparam int DEPTH   = 1 << AW;
  localparam int DW      = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [7:0]    cmd_data = '0;
  logic          xfer_stb = 1'b0;
  logic [1:0]    dma_ack = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    dma_req, dma_eot;
  logic [DW-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [DW-1:0] emem [2][DEPTH];

  always #(CLK_PER/2) clk = ~clk;

  dma_dual_buf #(.ADDR_W(AW), .DATA_W(DW)) i_dma_dual_buf (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .xfer_stb(xfer_stb), .dma_ack(dma_ack), .wr_data(wr_data),
    .dma_req(dma_req), .dma_eot(dma_eot), .rd_data(rd_data)
  );

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(int ch, int idx, int tag);
    return {8'(tag), 8'(ch + 1), 16'(idx * 37 + 5)};
  endfunction

  task automatic send_cmd(logic [7:0] v);
    cmd_wr = 1'b1; cmd_data = v;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0;
  endtask

  task automatic move(int ch, logic [DW-1:0] d);
    dma_ack[ch] = 1'b1; xfer_stb = 1'b1; wr_data = d;
    @(negedge clk);
    dma_ack = '0; xfer_stb = 1'b0;
  endtask

  // write n words on an already started channel, with gated stall cycles
  task automatic write_burst(int ch, int n, int tag);
    for (int k = 0; k < n; k++) begin
      if (k % 2 == 1) begin
        dma_ack[ch] = 1'b1; xfer_stb = 1'b0; wr_data = ~pat(ch, k, tag);
        @(negedge clk);
        dma_ack = '0; xfer_stb = 1'b1;
        @(negedge clk);
        xfer_stb = 1'b0;
      end
      move(ch, pat(ch, k, tag));
      emem[ch][k] = pat(ch, k, tag);
      check("R4 eot on write", 32'(dma_eot[ch]), 32'(k == DEPTH - 1));
    end
    if (n < DEPTH) check("R2 req held mid-write", 32'(dma_req[ch]), 32'd1);
  endtask

  task automatic read_burst(int ch, int n);
    send_cmd(ch == 0 ? 8'h04 : 8'h10);
    check("R6 read req", 32'(dma_req[ch]), 32'd1);
    for (int k = 0; k < n; k++) begin
      move(ch, 32'hDEAD_0000 + 32'(k));
      check("R6 read data", rd_data, emem[ch][k]);
      check("R6 read eot", 32'(dma_eot[ch]), 32'(k == n - 1));
    end
    check("R6 req low after read", 32'(dma_req[ch]), 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 req", 32'(dma_req), 32'd0);
    check("R1 eot", 32'(dma_eot), 32'd0);
    check("R1 rd_data", rd_data, 32'd0);

    // R2 full write on channel 1, request held while not acknowledged
    send_cmd(8'h08);
    check("R2 req rise", 32'(dma_req), 32'd1);
    for (int i = 0; i < 3; i++) @(negedge clk);
    check("R2 req held", 32'(dma_req[0]), 32'd1);
    write_burst(0, DEPTH, 1);
    check("R4 req low", 32'(dma_req[0]), 32'd0);
    @(negedge clk);
    check("R4 eot single", 32'(dma_eot[0]), 32'd0);
    send_cmd(8'h40);
    read_burst(0, DEPTH); // R3 R6 full read-back

    // R5 sweep of partial write lengths on channel 2
    for (int n = 1; n <= DEPTH; n++) begin
      send_cmd(8'h20);
      write_burst(1, n, 16 + n);
      send_cmd(8'h80);
      check("R5 req low after rewind", 32'(dma_req[1]), 32'd0);
      check("R5 no eot on rewind", 32'(dma_eot[1]), 32'd0);
      read_burst(1, n);
    end
    read_burst(0, DEPTH); // R11 channel 1 unchanged

    // R7 restart while busy
    send_cmd(8'h08);
    write_burst(0, 2, 40);
    send_cmd(8'h08);
    send_cmd(8'h04);
    for (int k = 2; k < DEPTH; k++) begin
      move(0, pat(0, k, 40));
      emem[0][k] = pat(0, k, 40);
      check("R7 end kept", 32'(dma_eot[0]), 32'(k == DEPTH - 1));
    end
    send_cmd(8'h40);
    read_burst(0, DEPTH);

    // R8 conflicting commands
    send_cmd(8'h0C);
    check("R8 both starts", 32'(dma_req[0]), 32'd0);
    send_cmd(8'h48);
    check("R8 start with rewind", 32'(dma_req[0]), 32'd0);
    send_cmd(8'h90);
    check("R8 ch2 read with rewind", 32'(dma_req[1]), 32'd0);

    // R10 zero read limit
    send_cmd(8'h20);
    send_cmd(8'h80);
    send_cmd(8'h10);
    check("R10 zero limit read", 32'(dma_req[1]), 32'd0);

    // R9 both channels acknowledged together
    send_cmd(8'h28);
    check("R9 both req", 32'(dma_req), 32'd3);
    for (int k = 0; k < DEPTH; k++) begin
      dma_ack = 2'b11; xfer_stb = 1'b1; wr_data = pat(0, k, 60);
      emem[0][k] = pat(0, k, 60);
      @(negedge clk);
      dma_ack = '0; xfer_stb = 1'b0;
    end
    check("R9 ch1 done", 32'(dma_eot), 32'd1);
    check("R9 ch2 still req", 32'(dma_req), 32'd2);
    write_burst(1, DEPTH, 61);
    send_cmd(8'hC0);
    read_burst(0, DEPTH);
    read_burst(1, DEPTH);

    finish_run();
  end

endmodule